// File: doc/BRIEF.md
# Two-Vector Delay-Test Scan Chain

The block is a scan chain of `N` cells. Each cell has a scan flip-flop and a hold register placed between that flip-flop and the combinational logic under test. The hold register lets the logic see one complete vector while the next vector is shifted in behind it. As a result, any pair of vectors, chosen independently, can be launched into the logic as a transition.

A built-in sequencer runs the whole delay test after one start strobe. The steps are:

1. Shift the first vector in.
2. Release it through the hold registers together with its primary-input portion.
3. Shift the second vector in.
4. Release the second vector, which launches the transition.
5. Capture the logic response with one clock.
6. Shift the response out.

While the response shifts out, it is compared bit by bit with an expected word. The outcome is reported as a pass flag next to a done flag.

Top module: `delay_pair_scan`

## Requirements
- R1: After reset the block is idle: `hold_o`=0, `test_o`=1, `done_o`=0, `pass_o`=0, `cut_drive_o`=0, `pi_drive_o`=0, `scan_out_o`=0.
- R2: A start strobe sampled in idle or done begins a load of exactly N clocks with `hold_o`=0 and `test_o`=0. Each load clock moves `scan_in_i` into cell 0 and cell i into cell i+1, so the first bit sent ends in cell N-1.
- R3: Each load is followed by one release clock with `hold_o`=1 and `test_o`=1. At its end the hold registers take the chain contents and `pi_drive_o` takes `vec_a_pi_i` (first release) or `vec_b_pi_i` (second release).
- R4: While `hold_o` is 0, the hold registers keep their value, so `cut_drive_o` holds the first vector throughout the second load.
- R5: The second load and release repeat R2 and R3 with the second vector, after which `cut_drive_o` shows the second vector and `pi_drive_o` shows `vec_b_pi_i`.
- R6: After the second release, one capture clock with `hold_o`=0 and `test_o`=1 loads `resp_i` into the chain.
- R7: The capture is followed by an unload of N clocks with `test_o`=0. `scan_out_o` is cell N-1, so in unload clock j the captured bit of cell N-1-j is visible.
- R8: In unload clock j, `scan_out_o` is compared with `expect_i[N-1-j]`. In the done state `pass_o`=1 exactly when all N bits matched. A new start clears the result.
- R9: `done_o` stays 1 until the next start. A start strobe during a running sequence is ignored.
- R10: Outside load, capture and unload clocks, the scan flip-flops do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one two-vector test |
| scan_in_i | input | 1 | Serial scan data into cell 0 |
| vec_a_pi_i | input | PI_W | Primary-input portion of the first vector |
| vec_b_pi_i | input | PI_W | Primary-input portion of the second vector |
| resp_i | input | N | Outputs of the logic under test, captured into the chain |
| expect_i | input | N | Expected captured response, indexed by cell |
| cut_drive_o | output | N | Hold register outputs driving the logic under test |
| pi_drive_o | output | PI_W | Primary-input drive to the logic under test |
| hold_o | output | 1 | Hold control (1 = hold registers load) |
| test_o | output | 1 | Test control (0 = shift) |
| scan_out_o | output | 1 | Serial scan data from cell N-1 |
| done_o | output | 1 | Sequence finished |
| pass_o | output | 1 | Response matched, valid with done |

## Verification
The bench builds the block with N=6 and PI_W=3. A chain length that is not a power of two exercises the shift counter's terminal count away from a natural wrap. A primary-input width smaller than N lets the modelled logic mix the primary-input drive into only some response bits. The modelled logic rotates the hold register outputs and XORs in the primary-input drive. A wrong capture, a wrong launch vector or a reversed scan order therefore each change the unloaded word. Runs cover a matching expectation, a deliberately wrong one combined with a start strobe during the second load, and a back-to-back restart from the done state.

// File: rtl/dps_pkg.sv
package dps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD_A = 3'd1,
        ST_REL_A  = 3'd2,
        ST_LOAD_B = 3'd3,
        ST_REL_B  = 3'd4,
        ST_CAPT   = 3'd5,
        ST_UNLOAD = 3'd6,
        ST_DONE   = 3'd7
    } dps_state_e;
endpackage

// File: rtl/dps_sequencer.sv
module dps_sequencer
    import dps_pkg::*;
#(
    parameter int N    = 8,
    parameter int PI_W = 4,
    parameter int CW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [PI_W-1:0] vec_a_i,
    input  logic [PI_W-1:0] vec_b_i,
    output logic            ck_en_o,
    output logic            hold_o,
    output logic            test_o,
    output logic [CW-1:0]   cnt_o,
    output logic            cmp_clr_o,
    output logic            cmp_en_o,
    output logic            done_o,
    output logic [PI_W-1:0] pi_o
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        dps_state_e      st;
        logic [CW-1:0]   cnt;
        logic [PI_W-1:0] pi;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_w;
    logic idle_like;
    logic shifting;

    always_comb begin
        seq_d     = seq_q;
        last_w    = (seq_q.cnt == LAST);
        idle_like = (seq_q.st == ST_IDLE) || (seq_q.st == ST_DONE);
        shifting  = (seq_q.st == ST_LOAD_A) || (seq_q.st == ST_LOAD_B) ||
                    (seq_q.st == ST_UNLOAD);
        case (seq_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    seq_d.st  = ST_LOAD_A;
                    seq_d.cnt = '0;
                end
            end
            ST_LOAD_A: begin
                if (last_w) begin
                    seq_d.st  = ST_REL_A;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_REL_A: begin
                seq_d.pi = vec_a_i;
                seq_d.st = ST_LOAD_B;
            end
            ST_LOAD_B: begin
                if (last_w) begin
                    seq_d.st  = ST_REL_B;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_REL_B: begin
                seq_d.pi = vec_b_i;
                seq_d.st = ST_CAPT;
            end
            ST_CAPT: begin
                seq_d.st  = ST_UNLOAD;
                seq_d.cnt = '0;
            end
            ST_UNLOAD: begin
                if (last_w) begin
                    seq_d.st  = ST_DONE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, pi: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ck_en_o   = shifting || (seq_q.st == ST_CAPT);
    assign test_o    = !shifting;
    assign hold_o    = (seq_q.st == ST_REL_A) || (seq_q.st == ST_REL_B);
    assign cnt_o     = seq_q.cnt;
    assign cmp_clr_o = idle_like && start_i;
    assign cmp_en_o  = (seq_q.st == ST_UNLOAD);
    assign done_o    = (seq_q.st == ST_DONE);
    assign pi_o      = seq_q.pi;

    AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> !hold_o); // R3
    AST_DONE_AFTER_UNLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(!test_o)); // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R9
endmodule

// File: rtl/dps_chain.sv
module dps_chain #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ck_en_i,
    input  logic         test_i,
    input  logic         hold_i,
    input  logic         scan_in_i,
    input  logic [N-1:0] resp_i,
    output logic         scan_out_o,
    output logic [N-1:0] drive_o
);
    typedef struct packed {
        logic [N-1:0] ff;
        logic [N-1:0] lat;
    } chain_t;

    chain_t cq, cd;
    logic [N-1:0] ser_w;

    for (genvar i = 0; i < N; i++) begin : g_cell
        if (i == 0) begin : g_head
            assign ser_w[i] = scan_in_i;
        end else begin : g_body
            assign ser_w[i] = cq.ff[i-1];
        end
    end

    always_comb begin
        cd = cq;
        if (ck_en_i) begin
            cd.ff = test_i ? resp_i : ser_w;
        end
        if (hold_i) begin
            cd.lat = cq.ff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq <= '0;
        end else begin
            cq <= cd;
        end
    end

    assign scan_out_o = cq.ff[N-1];
    assign drive_o    = cq.lat;

    AST_FF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_en_i |=> $stable(cq.ff)); // R10
    AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |=> $stable(drive_o)); // R4
endmodule

// File: rtl/dps_cmp.sv
module dps_cmp #(
    parameter int N  = 8,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          bit_i,
    input  logic [N-1:0]  expect_i,
    output logic          mism_o
);
    logic mism_d, mism_q;
    logic [CW-1:0] idx_w;

    always_comb begin
        idx_w  = CW'(N - 1) - cnt_i;
        mism_d = mism_q;
        if (clr_i) begin
            mism_d = 1'b0;
        end else if (en_i) begin
            mism_d = mism_q | (bit_i != expect_i[idx_w]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mism_q <= 1'b0;
        end else begin
            mism_q <= mism_d;
        end
    end

    assign mism_o = mism_q;

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !mism_o); // R8
endmodule

// File: rtl/delay_pair_scan.sv
module delay_pair_scan #(
    parameter int N    = 8,
    parameter int PI_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            scan_in_i,
    input  logic [PI_W-1:0] vec_a_pi_i,
    input  logic [PI_W-1:0] vec_b_pi_i,
    input  logic [N-1:0]    resp_i,
    input  logic [N-1:0]    expect_i,
    output logic [N-1:0]    cut_drive_o,
    output logic [PI_W-1:0] pi_drive_o,
    output logic            hold_o,
    output logic            test_o,
    output logic            scan_out_o,
    output logic            done_o,
    output logic            pass_o
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic          ck_en_w;
    logic [CW-1:0] cnt_w;
    logic          cmp_clr_w;
    logic          cmp_en_w;
    logic          mism_w;

    dps_sequencer #(.N(N), .PI_W(PI_W), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .vec_a_i   (vec_a_pi_i),
        .vec_b_i   (vec_b_pi_i),
        .ck_en_o   (ck_en_w),
        .hold_o    (hold_o),
        .test_o    (test_o),
        .cnt_o     (cnt_w),
        .cmp_clr_o (cmp_clr_w),
        .cmp_en_o  (cmp_en_w),
        .done_o    (done_o),
        .pi_o      (pi_drive_o)
    );

    dps_chain #(.N(N)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .ck_en_i    (ck_en_w),
        .test_i     (test_o),
        .hold_i     (hold_o),
        .scan_in_i  (scan_in_i),
        .resp_i     (resp_i),
        .scan_out_o (scan_out_o),
        .drive_o    (cut_drive_o)
    );

    dps_cmp #(.N(N), .CW(CW)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cmp_clr_w),
        .en_i     (cmp_en_w),
        .cnt_i    (cnt_w),
        .bit_i    (scan_out_o),
        .expect_i (expect_i),
        .mism_o   (mism_w)
    );

    assign pass_o = done_o && !mism_w;
endmodule

// File: tb/delay_pair_scan_tb_top.sv
module delay_pair_scan_tb_top;
    localparam int N    = 6;
    localparam int PI_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            scan_in_i = 1'b0;
    logic [PI_W-1:0] vec_a_pi_i = '0;
    logic [PI_W-1:0] vec_b_pi_i = '0;
    logic [N-1:0]    resp_i;
    logic [N-1:0]    expect_i = '0;
    logic [N-1:0]    cut_drive_o;
    logic [PI_W-1:0] pi_drive_o;
    logic            hold_o, test_o, scan_out_o, done_o, pass_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    function automatic logic [N-1:0] logic_fn(logic [N-1:0] a, logic [PI_W-1:0] p);
        return {a[N-2:0], a[N-1]} ^ {{(N-PI_W){1'b0}}, p};
    endfunction

    assign resp_i = logic_fn(cut_drive_o, pi_drive_o);

    delay_pair_scan #(.N(N), .PI_W(PI_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .scan_in_i   (scan_in_i),
        .vec_a_pi_i  (vec_a_pi_i),
        .vec_b_pi_i  (vec_b_pi_i),
        .resp_i      (resp_i),
        .expect_i    (expect_i),
        .cut_drive_o (cut_drive_o),
        .pi_drive_o  (pi_drive_o),
        .hold_o      (hold_o),
        .test_o      (test_o),
        .scan_out_o  (scan_out_o),
        .done_o      (done_o),
        .pass_o      (pass_o)
    );

    // behavioural reference: phase 0 idle,1 load a,2 release a,3 load b,
    // 4 release b,5 capture,6 unload,7 done
    int            m_phase = 0;
    int            m_cnt = 0;
    logic [N-1:0]  m_ff = '0;
    logic [N-1:0]  m_lat = '0;
    logic [PI_W-1:0] m_pi = '0;
    logic          m_mism = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_ff = '0; m_lat = '0; m_pi = '0; m_mism = 1'b0;
        end else begin
            case (m_phase)
                0, 7: if (start_i) begin m_phase = 1; m_cnt = 0; m_mism = 1'b0; end
                1, 3: begin
                    m_ff = {m_ff[N-2:0], scan_in_i};
                    if (m_cnt == N-1) begin m_phase = m_phase + 1; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end
                2: begin m_lat = m_ff; m_pi = vec_a_pi_i; m_phase = 3; end
                4: begin m_lat = m_ff; m_pi = vec_b_pi_i; m_phase = 5; end
                5: begin m_ff = logic_fn(m_lat, m_pi); m_phase = 6; m_cnt = 0; end
                6: begin
                    if (m_ff[N-1] != expect_i[N-1-m_cnt]) m_mism = 1'b1;
                    m_ff = {m_ff[N-2:0], scan_in_i};
                    if (m_cnt == N-1) begin m_phase = 7; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // per-clock comparison against the reference, 5 ns after the edge
    always @(posedge clk) begin
        cycles++;
        if (rst_n) begin
            #5;
            chk("R2 hold_o", 32'(hold_o), 32'((m_phase == 2) || (m_phase == 4)));
            chk("R2 test_o", 32'(test_o), 32'(!((m_phase == 1) || (m_phase == 3) || (m_phase == 6))));
            chk("R9 done_o", 32'(done_o), 32'(m_phase == 7));
            chk("R8 pass_o", 32'(pass_o), 32'((m_phase == 7) && !m_mism));
            chk("R7 scan_out_o", 32'(scan_out_o), 32'(m_ff[N-1]));
            chk("R4 cut_drive_o", 32'(cut_drive_o), 32'(m_lat));
            chk("R3 pi_drive_o", 32'(pi_drive_o), 32'(m_pi));
        end
    end

    initial begin
        wait (cycles > 20000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic run_pair(input logic [N-1:0] va, input logic [N-1:0] vb,
                            input logic [PI_W-1:0] pa, input logic [PI_W-1:0] pb,
                            input logic [N-1:0] ex, input logic exp_pass, input bit poke);
        @(negedge clk);
        vec_a_pi_i = pa; vec_b_pi_i = pb; expect_i = ex; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 load entered", 32'(test_o), 32'(0));
        while (m_phase != 7) begin
            start_i = 1'b0;
            if (m_phase == 1) scan_in_i = va[N-1-m_cnt];
            else if (m_phase == 3) scan_in_i = vb[N-1-m_cnt];
            else scan_in_i = 1'b1;
            if (m_phase == 3) begin
                chk("R4 first vector held during second load", 32'(cut_drive_o), 32'(va));
                if (m_cnt == 0) chk("R3 first pi released", 32'(pi_drive_o), 32'(pa));
                if (poke && m_cnt == 2) start_i = 1'b1;
            end
            if (m_phase == 5) begin
                chk("R5 second vector released", 32'(cut_drive_o), 32'(vb));
                chk("R5 second pi released", 32'(pi_drive_o), 32'(pb));
                chk("R6 capture control", 32'({hold_o, test_o}), 32'(2'b01));
            end
            if (m_phase == 6 && m_cnt == 0)
                chk("R7 first unloaded bit", 32'(scan_out_o), 32'(logic_fn(vb, pb) >> (N-1)) & 32'h1);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk("R8 pass result", 32'(pass_o), 32'(exp_pass));
        chk("R9 done raised", 32'(done_o), 32'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 hold", 32'(hold_o), 32'(0));
        chk("R1 test", 32'(test_o), 32'(1));
        chk("R1 done", 32'(done_o), 32'(0));
        chk("R1 pass", 32'(pass_o), 32'(0));
        chk("R1 cut_drive", 32'(cut_drive_o), 32'(0));
        chk("R1 pi_drive", 32'(pi_drive_o), 32'(0));
        chk("R1 scan_out", 32'(scan_out_o), 32'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 idle chain frozen", 32'(scan_out_o), 32'(0));

        run_pair(6'b101100, 6'b010111, 3'b101, 3'b011,
                 logic_fn(6'b010111, 3'b011), 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        chk("R9 done sticky", 32'(done_o), 32'(1));
        chk("R8 pass sticky", 32'(pass_o), 32'(1));

        run_pair(6'b111111, 6'b000000, 3'b111, 3'b000,
                 logic_fn(6'b000000, 3'b000) ^ 6'b000100, 1'b0, 1'b1);

        run_pair(6'b000001, 6'b100000, 3'b010, 3'b110,
                 logic_fn(6'b100000, 3'b110), 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        chk("R10 done chain frozen", 32'(scan_out_o), 32'(m_ff[N-1]));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule